// File: doc/BRIEF.md
# TLB Shootdown Launch Sequencer

This block carries out one translation shootdown on behalf of a requester. A request gives a process ID, an optional virtual address and a page size in bytes. The block drives a small register set through a memory-mapped master port: when the address is non-zero it first stores the page-aligned part of the address, then it writes a launch word that encodes the scope, page size and process ID, and then it reads a status register again and again until the target reports that the shootdown has finished.

Polling is bounded by a programmable cycle limit. The block ends each request with a one-cycle `done` or `timedOut` pulse. If no register base is configured, a request is still accepted but causes no bus traffic. The block takes a new request only while idle.

Top module: `shootdown_launcher`

## Requirements
- R1: After reset `reqReady` is 1 and `busValid`, `done` and `timedOut` are 0.
- R2: With a non-zero address, the first bus access is a write to offset 0 whose data is the address shifted right by 12 bits. The launch write follows it.
- R3: With a zero address, there is no write to offset 0. The first bus access is the launch write to offset 1.
- R4: The launch word always has bit 0 set, bit 1 set, and bits [3:2] equal to 2'b10.
- R5: With an address, launch bits [5:4] are 2'b00 and bit 6 is 0. Without an address, bits [5:4] are 2'b01 and bit 6 is 1.
- R6: Launch bits [9:7] hold the page code: 4096 bytes gives 3'b000, 2 MiB gives 3'b001, 1 GiB gives 3'b010, and every other size gives 3'b101.
- R7: Launch bits [12+PID_W-1:12] hold the process ID. All launch bits not named in R4 to R7 are 0.
- R8: After the launch write, the block issues reads of offset 2 while the returned bit 63 is 1. The first read that returns bit 63 equal to 0 ends the request with a `done` pulse exactly one cycle long.
- R9: With a limit of L and a target that answers at once but stays pending, the block makes exactly L+1 status reads. It then pulses `timedOut` for one cycle and does not raise `done`.
- R10: A request accepted while `baseValid` is 0 makes no bus access. `done` pulses in the next cycle.
- R11: `reqReady` stays 0 from the cycle after acceptance until the result pulse. It is 1 again in the cycle after the pulse.
- R12: While `busValid` is 1 and `busReady` is 0, the offset, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseValid | input | 1 | Register base is configured |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block is idle and takes the request |
| reqPid | input | PID_W | Process ID |
| reqAddr | input | 64 | Virtual address; zero means whole process |
| reqPageSize | input | 64 | Page size in bytes |
| timeoutLimit | input | TMO_W | Poll window in cycles |
| busValid | output | 1 | Register access request |
| busWrite | output | 1 | 1 = write, 0 = read |
| busOffset | output | 2 | Register select: 0 address, 1 launch, 2 status |
| busWdata | output | 64 | Write data |
| busReady | input | 1 | Access accepted this cycle |
| busRdata | input | 64 | Read data, valid with `busReady` on a read |
| done | output | 1 | One-cycle completion pulse |
| timedOut | output | 1 | One-cycle timeout pulse |

## Verification
The bench uses the default parameters: PID_W = 20, which places the process ID field in bits [31:12], and TMO_W = 16. The timeout limit is a port, so the bench can set it to 0 or 5. At those values timeout expiry and the exact L+1 read count are reached within a few cycles. A bus responder in the bench stays pending for a chosen number of status reads and can insert wait states every other cycle. These wait states exercise the hold rule and show that polling still ends correctly when some cycles have no handshake.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int DATA_W = 64;
  localparam int VA_SHIFT = 12;
  localparam int PEND_BIT = 63;

  localparam logic [1:0] OFF_AVA    = 2'd0;
  localparam logic [1:0] OFF_LAUNCH = 2'd1;
  localparam logic [1:0] OFF_STATUS = 2'd2;

  // launch word field positions
  localparam int B_R      = 0;
  localparam int B_PRS    = 1;
  localparam int B_RIC    = 2;
  localparam int B_IS     = 4;
  localparam int B_SINGLE = 6;
  localparam int B_AP     = 7;
  localparam int B_PID    = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_AVA, ST_LAUNCH, ST_POLL, ST_OK, ST_TMO
  } sdlState_t;

  typedef struct packed {
    logic captureReq;
    logic loadTimer;
    logic tickTimer;
    logic selLaunch;
  } sdlStrobe_t;
endpackage

// File: rtl/sdl_pagecode.sv
module sdl_pagecode (
  input  logic [63:0] pageBytes,
  output logic [2:0]  code
);
  always_comb begin
    case (pageBytes)
      64'h0000_0000_0000_1000: code = 3'b000;
      64'h0000_0000_0020_0000: code = 3'b001;
      64'h0000_0000_4000_0000: code = 3'b010;
      default:                 code = 3'b101;
    endcase
  end
endmodule

// File: rtl/sdl_datapath.sv
module sdl_datapath
  import sdl_pkg::*;
#(
  parameter int PID_W = 20,
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdlStrobe_t        stb,
  input  logic [PID_W-1:0]  reqPid,
  input  logic [63:0]       reqAddr,
  input  logic [63:0]       reqPageSize,
  input  logic [TMO_W-1:0]  timeoutLimit,
  output logic              inAddrNonZero,
  output logic              timerZero,
  output logic [DATA_W-1:0] busWdata
);
  localparam int VA_W = DATA_W - VA_SHIFT;

  logic [2:0]       pageCode;
  logic [PID_W-1:0] pidQ;
  logic [VA_W-1:0]  vaQ;
  logic             hasAddrQ;
  logic [2:0]       codeQ;
  logic [TMO_W-1:0] timerQ;
  logic [DATA_W-1:0] launchWord;
  logic [DATA_W-1:0] avaWord;

  sdl_pagecode u_pagecode (
    .pageBytes(reqPageSize),
    .code     (pageCode)
  );

  assign inAddrNonZero = |reqAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pidQ     <= '0;
      vaQ      <= '0;
      hasAddrQ <= 1'b0;
      codeQ    <= 3'b000;
      timerQ   <= '0;
    end else begin
      if (stb.captureReq) begin
        pidQ     <= reqPid;
        vaQ      <= reqAddr[DATA_W-1:VA_SHIFT];
        hasAddrQ <= inAddrNonZero;
        codeQ    <= pageCode;
      end
      if (stb.loadTimer)
        timerQ <= timeoutLimit;
      else if (stb.tickTimer && (timerQ != '0))
        timerQ <= timerQ - 1'b1;
    end
  end

  assign timerZero = (timerQ == '0);

  always_comb begin
    launchWord = '0;
    launchWord[B_R]          = 1'b1;
    launchWord[B_PRS]        = 1'b1;
    launchWord[B_RIC +: 2]   = 2'b10;
    launchWord[B_IS +: 2]    = hasAddrQ ? 2'b00 : 2'b01;
    launchWord[B_SINGLE]     = ~hasAddrQ;
    launchWord[B_AP +: 3]    = codeQ;
    launchWord[B_PID +: PID_W] = pidQ;
  end

  assign avaWord  = {{VA_SHIFT{1'b0}}, vaQ};
  assign busWdata = stb.selLaunch ? launchWord : avaWord;
endmodule

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
  import sdl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       baseValid,
  input  logic       inAddrNonZero,
  input  logic       timerZero,
  input  logic       busReady,
  input  logic       statusPending,
  output logic       reqReady,
  output sdlStrobe_t stb,
  output logic       busValid,
  output logic       busWrite,
  output logic [1:0] busOffset,
  output logic       done,
  output logic       timedOut
);
  sdlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    busValid  = 1'b0;
    busWrite  = 1'b0;
    busOffset = OFF_AVA;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.captureReq = 1'b1;
          if (!baseValid)         stateNext = ST_OK;
          else if (inAddrNonZero) stateNext = ST_AVA;
          else                    stateNext = ST_LAUNCH;
        end
      end
      ST_AVA: begin
        busValid  = 1'b1;
        busWrite  = 1'b1;
        busOffset = OFF_AVA;
        if (busReady) stateNext = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        busValid      = 1'b1;
        busWrite      = 1'b1;
        busOffset     = OFF_LAUNCH;
        stb.selLaunch = 1'b1;
        if (busReady) begin
          stb.loadTimer = 1'b1;
          stateNext     = ST_POLL;
        end
      end
      ST_POLL: begin
        busValid      = 1'b1;
        busOffset     = OFF_STATUS;
        stb.tickTimer = 1'b1;
        if (busReady) begin
          if (!statusPending) stateNext = ST_OK;
          else if (timerZero) stateNext = ST_TMO;
        end
      end
      ST_OK:   stateNext = ST_IDLE;
      ST_TMO:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign done     = (state == ST_OK);
  assign timedOut = (state == ST_TMO);
endmodule

// File: rtl/shootdown_launcher.sv
module shootdown_launcher
  import sdl_pkg::*;
#(
  parameter int PID_W = 20,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseValid,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [PID_W-1:0] reqPid,
  input  logic [63:0]      reqAddr,
  input  logic [63:0]      reqPageSize,
  input  logic [TMO_W-1:0] timeoutLimit,
  output logic             busValid,
  output logic             busWrite,
  output logic [1:0]       busOffset,
  output logic [63:0]      busWdata,
  input  logic             busReady,
  input  logic [63:0]      busRdata,
  output logic             done,
  output logic             timedOut
);
  sdlStrobe_t stb;
  logic inAddrNonZero;
  logic timerZero;
  logic rdUnused;

  assign rdUnused = ^busRdata[PEND_BIT-1:0];

  sdl_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .baseValid    (baseValid),
    .inAddrNonZero(inAddrNonZero),
    .timerZero    (timerZero),
    .busReady     (busReady),
    .statusPending(busRdata[PEND_BIT]),
    .reqReady     (reqReady),
    .stb          (stb),
    .busValid     (busValid),
    .busWrite     (busWrite),
    .busOffset    (busOffset),
    .done         (done),
    .timedOut     (timedOut)
  );

  sdl_datapath #(.PID_W(PID_W), .TMO_W(TMO_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .reqPid       (reqPid),
    .reqAddr      (reqAddr),
    .reqPageSize  (reqPageSize),
    .timeoutLimit (timeoutLimit),
    .inAddrNonZero(inAddrNonZero),
    .timerZero    (timerZero),
    .busWdata     (busWdata)
  );
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker
  import sdl_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        baseValid,
  input logic        reqValid,
  input logic        reqReady,
  input logic        busValid,
  input logic        busWrite,
  input logic [1:0]  busOffset,
  input logic [63:0] busWdata,
  input logic        busReady,
  input logic        done,
  input logic        timedOut
);
  a_r12_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busOffset) && $stable(busWrite) && $stable(busWdata)));

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timedOut));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_tmo_pulse: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |=> !timedOut);

  a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !reqReady);

  a_r11_back_idle: assert property (@(posedge clk) disable iff (!rstN)
    (done || timedOut) |=> reqReady);

  a_r10_no_base: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !baseValid) |=> (done && !busValid));

  a_r4_launch_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busOffset == OFF_LAUNCH) |->
      (busWdata[B_R] && busWdata[B_PRS] && busWdata[B_RIC +: 2] == 2'b10));
endmodule

bind shootdown_launcher sdl_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .baseValid(baseValid),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .busValid (busValid),
  .busWrite (busWrite),
  .busOffset(busOffset),
  .busWdata (busWdata),
  .busReady (busReady),
  .done     (done),
  .timedOut (timedOut)
);

// File: tb/shootdown_launcher_tb.sv
`timescale 1ns/1ps
module shootdown_launcher_tb;
  localparam int PID_W = 20;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baseValid = 1'b1;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [PID_W-1:0] reqPid = '0;
  logic [63:0] reqAddr = '0;
  logic [63:0] reqPageSize = '0;
  logic [TMO_W-1:0] timeoutLimit = '0;
  logic busValid, busWrite;
  logic [1:0] busOffset;
  logic [63:0] busWdata;
  logic busReady;
  logic [63:0] busRdata;
  logic done, timedOut;

  int checks = 0;
  int failures = 0;

  // responder state
  logic stallOn = 1'b0;
  logic phase = 1'b0;
  int logCount = 0;
  int statCount = 0;
  int statBase = 0;
  int pendTarget = 0;
  logic [1:0]  logOff  [0:255];
  logic        logWr   [0:255];
  logic [63:0] logData [0:255];

  always #2 clk = ~clk;

  shootdown_launcher #(.PID_W(PID_W), .TMO_W(TMO_W)) u_dut (
    .clk(clk), .rstN(rstN), .baseValid(baseValid),
    .reqValid(reqValid), .reqReady(reqReady), .reqPid(reqPid),
    .reqAddr(reqAddr), .reqPageSize(reqPageSize), .timeoutLimit(timeoutLimit),
    .busValid(busValid), .busWrite(busWrite), .busOffset(busOffset),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata),
    .done(done), .timedOut(timedOut)
  );

  assign busReady = stallOn ? phase : 1'b1;
  assign busRdata = ((statCount - statBase) < pendTarget) ? 64'h8000_0000_0000_00F0
                                                          : 64'h7FFF_0000_0000_000F;

  always @(posedge clk) begin
    phase <= ~phase;
    if (rstN && busValid && busReady) begin
      logOff[logCount[7:0]]  <= busOffset;
      logWr[logCount[7:0]]   <= busWrite;
      logData[logCount[7:0]] <= busWdata;
      logCount <= logCount + 1;
      if (!busWrite && busOffset == 2'd2) statCount <= statCount + 1;
    end
  end

  task automatic chk(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expLaunch(input logic [PID_W-1:0] pid, input logic hasAddr, input logic [63:0] size);
    logic [63:0] w;
    logic [2:0] c;
    w = '0;
    w[0] = 1'b1;
    w[1] = 1'b1;
    w[3:2] = 2'b10;
    w[5:4] = hasAddr ? 2'b00 : 2'b01;
    w[6] = ~hasAddr;
    if (size == 64'h1000)          c = 3'b000;
    else if (size == 64'h20_0000)  c = 3'b001;
    else if (size == 64'h4000_0000) c = 3'b010;
    else                           c = 3'b101;
    w[9:7] = c;
    w[12 +: PID_W] = pid;
    return w;
  endfunction

  int rOps, rStart, rDone, rTmo, rBusyReady;

  task automatic runReq(input logic [PID_W-1:0] pid, input logic [63:0] addr, input logic [63:0] size,
                        input int pend, input logic [TMO_W-1:0] limit, input logic stall);
    int seen;
    @(negedge clk);
    reqPid = pid; reqAddr = addr; reqPageSize = size; timeoutLimit = limit;
    stallOn = stall;
    statBase = statCount; pendTarget = pend; rStart = logCount;
    rDone = 0; rTmo = 0; rBusyReady = 0; seen = 0;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 1000; c++) begin
      if (done || timedOut) begin
        rDone = done; rTmo = timedOut; seen = 1;
        break;
      end
      if (reqReady) rBusyReady++;
      @(negedge clk);
    end
    chk("R8/R9 request finished", seen == 1, seen, 1);
    @(negedge clk);
    chk("R11 idle after pulse", reqReady && !done && !timedOut, {reqReady, done, timedOut}, 3'b100);
    rOps = logCount - rStart;
    stallOn = 1'b0;
  endtask

  function automatic int ix(input int k);
    return (rStart + k) % 256;
  endfunction

  task automatic t_reset;
    chk("R1 reset reqReady", reqReady == 1'b1, reqReady, 1);
    chk("R1 reset outputs quiet", !busValid && !done && !timedOut, {busValid, done, timedOut}, 0);
  endtask

  task automatic t_addr_4k;
    logic [63:0] a = 64'h0000_1234_5678_9ABC;
    runReq(20'h12345, a, 64'h1000, 2, 16'd20, 1'b0);
    chk("R8 op count with address", rOps == 5, rOps, 5);
    chk("R2 first op is address write", logWr[ix(0)] && logOff[ix(0)] == 2'd0, {logWr[ix(0)], logOff[ix(0)]}, 3'b100);
    chk("R2 address data", logData[ix(0)] == (a >> 12), logData[ix(0)], a >> 12);
    chk("R2 launch follows", logWr[ix(1)] && logOff[ix(1)] == 2'd1, logOff[ix(1)], 1);
    chk("R4 R5 R6 R7 launch word 4k", logData[ix(1)] == expLaunch(20'h12345, 1'b1, 64'h1000),
        logData[ix(1)], expLaunch(20'h12345, 1'b1, 64'h1000));
    for (int k = 2; k < 5; k++)
      chk("R8 status read", !logWr[ix(k)] && logOff[ix(k)] == 2'd2, {logWr[ix(k)], logOff[ix(k)]}, 2);
    chk("R8 done raised", rDone == 1 && rTmo == 0, {rDone[0], rTmo[0]}, 2'b10);
    chk("R11 not ready while busy", rBusyReady == 0, rBusyReady, 0);
  endtask

  task automatic t_noaddr_2m;
    runReq(20'hABCDE, 64'h0, 64'h20_0000, 0, 16'd20, 1'b0);
    chk("R3 op count without address", rOps == 2, rOps, 2);
    chk("R3 first op is launch", logWr[ix(0)] && logOff[ix(0)] == 2'd1, {logWr[ix(0)], logOff[ix(0)]}, 3'b101);
    chk("R5 R6 R7 launch word 2M", logData[ix(0)] == expLaunch(20'hABCDE, 1'b0, 64'h20_0000),
        logData[ix(0)], expLaunch(20'hABCDE, 1'b0, 64'h20_0000));
    chk("R8 done on first clear read", rDone == 1, rDone, 1);
  endtask

  task automatic t_1g_stall;
    logic [63:0] a = 64'hFFFF_F000_0000_1000;
    runReq(20'h00F0F, a, 64'h4000_0000, 1, 16'd100, 1'b1);
    chk("R12 op count under wait states", rOps == 4, rOps, 4);
    chk("R12 address data under wait states", logData[ix(0)] == (a >> 12), logData[ix(0)], a >> 12);
    chk("R6 launch word 1G", logData[ix(1)] == expLaunch(20'h00F0F, 1'b1, 64'h4000_0000),
        logData[ix(1)], expLaunch(20'h00F0F, 1'b1, 64'h4000_0000));
    chk("R8 done under wait states", rDone == 1, rDone, 1);
  endtask

  task automatic t_other_sizes;
    runReq(20'h00001, 64'h0, 64'h1_0000, 0, 16'd4, 1'b0);
    chk("R6 64K code 101", logData[ix(0)][9:7] == 3'b101, logData[ix(0)][9:7], 3'b101);
    runReq(20'hFFFFF, 64'h0, 64'h2000, 0, 16'd4, 1'b0);
    chk("R6 8K falls to 101", logData[ix(0)][9:7] == 3'b101, logData[ix(0)][9:7], 3'b101);
    chk("R7 full pid field", logData[ix(0)] == expLaunch(20'hFFFFF, 1'b0, 64'h2000),
        logData[ix(0)], expLaunch(20'hFFFFF, 1'b0, 64'h2000));
  endtask

  task automatic t_timeout;
    runReq(20'h00042, 64'h0, 64'h1000, 1000, 16'd5, 1'b0);
    chk("R9 reads before timeout L=5", rOps == 7, rOps, 7);
    chk("R9 timeout raised, no done", rTmo == 1 && rDone == 0, {rDone[0], rTmo[0]}, 2'b01);
    runReq(20'h00043, 64'h0, 64'h1000, 1000, 16'd0, 1'b0);
    chk("R9 single read at L=0", rOps == 2, rOps, 2);
    chk("R9 timeout at L=0", rTmo == 1, rTmo, 1);
  endtask

  task automatic t_nobase;
    baseValid = 1'b0;
    runReq(20'h00777, 64'h1234_5000, 64'h1000, 3, 16'd5, 1'b0);
    chk("R10 no bus access without base", rOps == 0, rOps, 0);
    chk("R10 done without base", rDone == 1 && rTmo == 0, {rDone[0], rTmo[0]}, 2'b10);
    baseValid = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_4k();
    t_noaddr_2m();
    t_1g_stall();
    t_other_sizes();
    t_timeout();
    t_nobase();
    t_addr_4k();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule